// File: doc/BRIEF.md
# Bidirectional Reset Pin Sequencer

This block runs an open-drain reset pin that is both an input and an output. At power-up it pulls the pin low and holds it there until the clock generator's PLL reports lock. It then lets the pin go for a short probe. If the external pull-up brings the line high during the probe, the reset is taken to be a power-on reset and the core is released at once. If the line stays low, something outside is holding it. The block then classifies the reset as external and stretches it: it pulls the pin low for a long window, releases it for a short window, and samples it. It repeats this until the line is seen high.

The pin level enters through a synchronizer, and every decision is made on the synchronized level. A flag records which kind of reset completed last. While the core runs, a low on the pin starts the external stretch again. Losing PLL lock at any time returns the block to the initial hold-low state.

Top module: `rst_pin_seq`

## Requirements
- R1: While rst_ni is low, and whenever pll_lock_i is low, pin_drive_o and core_rst_o are 1. After rst_ni is released por_flag_o is 0.
- R2: On the first clock edge with pll_lock_i high, the block leaves the hold state. pin_drive_o then stays 0 for PROBE_CYCLES+SYNC_STAGES cycles (4 by default). Only the pin level during the first PROBE_CYCLES (2) released cycles counts toward the verdict.
- R3: If the pin was high in any of those first 2 released cycles, core_rst_o goes to 0 in the cycle after the probe, por_flag_o becomes 1, and pin_drive_o stays 0.
- R4: If the pin was low through the whole observation, pin_drive_o is 1 for exactly LOW_CYCLES (512) cycles.
- R5: Each drive-low window is followed by a release window of REL_CYCLES (10) cycles with pin_drive_o at 0. The verdict depends only on the pin level in the release window's 8th cycle, which is the last level the synchronizer delivers in time. A pin that rises in the 9th or 10th cycle is not seen.
- R6: The drive-low/release loop repeats without limit until the verdict is high. core_rst_o is 1 throughout, and in every cycle where pin_drive_o is 1.
- R7: A high verdict at the end of a release window sets core_rst_o to 0 in the next cycle with pin_drive_o at 0, and sets por_flag_o to 0 (external).
- R8: por_flag_o changes only in the cycle where core_rst_o falls.
- R9: While the core runs, a pin low lasting even one cycle sets pin_drive_o and core_rst_o to 1 on the third clock edge after it. The block then runs the drive-low/release loop.
- R10: pll_lock_i low at a clock edge sets pin_drive_o and core_rst_o to 1 in the next cycle, from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| pll_lock_i | input | 1 | PLL lock indication |
| pin_i | input | 1 | Level read back from the reset pin (asynchronous) |
| pin_drive_o | output | 1 | Pull-down enable for the open-drain pin, active high |
| core_rst_o | output | 1 | Reset to the core, active high |
| por_flag_o | output | 1 | 1 = last completed reset was power-on, 0 = external |

## Verification
The bench tests the synchronizer-shifted edges of both sampling windows. In the probe, a pin that rises in the second released cycle must count as power-on, and one that rises in the third must not. In the release window, a rise in the 8th cycle must end the loop, and a rise in the 9th must cost one more full loop. A design that samples the raw pin, or that ignores the synchronizer delay, misclassifies one of these cases. The bench counts every drive-low and release window against the set lengths over one to three loops, which catches off-by-one counter reloads. It also checks that a one-cycle low while running re-enters the loop three edges later, that the flag holds its old value until the new sequence completes, and that lock loss in both the running and drive-low states returns the block to hold.

// File: rtl/rps_pkg.sv
package rps_pkg;
  typedef enum logic [2:0] {
    ST_HOLD,
    ST_PROBE,
    ST_DRIVE,
    ST_REL,
    ST_RUN
  } rps_state_e;
endpackage

// File: rtl/rps_sync.sv
module rps_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  // resets low: the pin is driven low during power-on reset
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/rps_timer.sv
module rps_timer #(
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/rps_fsm.sv
module rps_fsm
  import rps_pkg::*;
#(
  parameter int LOW_CYCLES   = 512,
  parameter int REL_CYCLES   = 10,
  parameter int PROBE_CYCLES = 2,
  parameter int SYNC_STAGES  = 2,
  parameter int CW           = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pll_lock_i,
  input  logic          pin_hi_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          zero_i,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output rps_state_e    state_o,
  output logic          por_flag_o
);
  localparam int PROBE_LEN = PROBE_CYCLES + SYNC_STAGES;
  localparam logic [CW-1:0] LV_LOW   = CW'(LOW_CYCLES - 1);
  localparam logic [CW-1:0] LV_REL   = CW'(REL_CYCLES - 1);
  localparam logic [CW-1:0] LV_PROBE = CW'(PROBE_LEN - 1);
  localparam logic [CW-1:0] OBS_LIM  = CW'(PROBE_CYCLES);

  rps_state_e state_q, state_d;
  logic       flag_q, flag_d;
  logic       seen_q, seen_d;

  // synchronized level lags the pin by SYNC_STAGES; the last PROBE_CYCLES
  // probe cycles therefore observe the first PROBE_CYCLES released cycles
  assign seen_d = (state_q == ST_PROBE) && (seen_q || (pin_hi_i && cnt_i < OBS_LIM));

  always_comb begin
    state_d    = state_q;
    flag_d     = flag_q;
    load_o     = 1'b0;
    load_val_o = '0;
    if (!pll_lock_i) begin
      state_d = ST_HOLD;
    end else begin
      unique case (state_q)
        ST_HOLD: begin
          state_d    = ST_PROBE;
          load_o     = 1'b1;
          load_val_o = LV_PROBE;
        end
        ST_PROBE: if (zero_i) begin
          if (seen_q || pin_hi_i) begin
            state_d = ST_RUN;
            flag_d  = 1'b1;
          end else begin
            state_d    = ST_DRIVE;
            load_o     = 1'b1;
            load_val_o = LV_LOW;
          end
        end
        ST_DRIVE: if (zero_i) begin
          state_d    = ST_REL;
          load_o     = 1'b1;
          load_val_o = LV_REL;
        end
        ST_REL: if (zero_i) begin
          if (pin_hi_i) begin
            state_d = ST_RUN;
            flag_d  = 1'b0;
          end else begin
            state_d    = ST_DRIVE;
            load_o     = 1'b1;
            load_val_o = LV_LOW;
          end
        end
        ST_RUN: if (!pin_hi_i) begin
          state_d    = ST_DRIVE;
          load_o     = 1'b1;
          load_val_o = LV_LOW;
        end
        default: state_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      flag_q  <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      flag_q  <= flag_d;
      seen_q  <= seen_d;
    end
  end

  assign state_o    = state_q;
  assign por_flag_o = flag_q;
endmodule

// File: rtl/rst_pin_seq.sv
module rst_pin_seq
  import rps_pkg::*;
#(
  parameter int LOW_CYCLES   = 512,
  parameter int REL_CYCLES   = 10,
  parameter int PROBE_CYCLES = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pll_lock_i,
  input  logic pin_i,
  output logic pin_drive_o,
  output logic core_rst_o,
  output logic por_flag_o
);
  localparam int CW = $clog2(LOW_CYCLES) + 1;

  logic          pin_hi;
  logic          load;
  logic [CW-1:0] load_val;
  logic [CW-1:0] cnt;
  logic          zero;
  rps_state_e    state;

  rps_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_hi)
  );

  rps_timer #(.CW(CW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .cnt_o     (cnt),
    .zero_o    (zero)
  );

  rps_fsm #(
    .LOW_CYCLES  (LOW_CYCLES),
    .REL_CYCLES  (REL_CYCLES),
    .PROBE_CYCLES(PROBE_CYCLES),
    .SYNC_STAGES (SYNC_STAGES),
    .CW          (CW)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pll_lock_i(pll_lock_i),
    .pin_hi_i  (pin_hi),
    .cnt_i     (cnt),
    .zero_i    (zero),
    .load_o    (load),
    .load_val_o(load_val),
    .state_o   (state),
    .por_flag_o(por_flag_o)
  );

  assign pin_drive_o = (state == ST_HOLD) || (state == ST_DRIVE);
  assign core_rst_o  = (state != ST_RUN);
endmodule

// File: rtl/rps_checker.sv
module rps_checker #(
  parameter int LOW_CYCLES   = 512,
  parameter int REL_CYCLES   = 10,
  parameter int PROBE_CYCLES = 2,
  parameter int SYNC_STAGES  = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pll_lock_i,
  input logic pin_drive_o,
  input logic core_rst_o,
  input logic por_flag_o
);
  localparam int PROBE_LEN = PROBE_CYCLES + SYNC_STAGES;
  localparam int REL_MAX   = (REL_CYCLES > PROBE_LEN) ? REL_CYCLES : PROBE_LEN;
  localparam int KW        = $clog2(LOW_CYCLES + 2) + 1;

  logic [KW-1:0] drv_run_q, rel_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_run_q <= '0;
      rel_run_q <= '0;
    end else begin
      drv_run_q <= (pin_drive_o && pll_lock_i) ? drv_run_q + 1'b1 : '0;
      rel_run_q <= (!pin_drive_o && core_rst_o) ? rel_run_q + 1'b1 : '0;
    end
  end

  AST_DRIVE_WIN_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(drv_run_q) <= LOW_CYCLES); // R4

  AST_RELEASE_WIN_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(rel_run_q) <= REL_MAX); // R5

  AST_DRIVE_IMPLIES_CORE_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_drive_o |-> core_rst_o); // R6

  AST_EXIT_AFTER_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_rst_o) |-> (!pin_drive_o && $past(!pin_drive_o))); // R7

  AST_FLAG_ONLY_AT_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(por_flag_o) |-> $fell(core_rst_o)); // R8

  AST_LOCK_LOSS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pll_lock_i |=> (pin_drive_o && core_rst_o)); // R10
endmodule

bind rst_pin_seq rps_checker #(
  .LOW_CYCLES  (LOW_CYCLES),
  .REL_CYCLES  (REL_CYCLES),
  .PROBE_CYCLES(PROBE_CYCLES),
  .SYNC_STAGES (SYNC_STAGES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pll_lock_i (pll_lock_i),
  .pin_drive_o(pin_drive_o),
  .core_rst_o (core_rst_o),
  .por_flag_o (por_flag_o)
);

// File: tb/rst_pin_seq_tb.sv
module rst_pin_seq_tb;
  localparam int LOW = 512;
  localparam int REL = 10;
  localparam int PRB = 2;
  localparam int SYN = 2;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lock = 1'b0;
  logic ext_low = 1'b0;
  logic pin, drive, core_rst, por_flag;
  int   n_chk = 0;
  int   n_fail = 0;
  int   cyc = 0;

  always #5 clk = ~clk;

  // open-drain line: high unless the block or the outside agent pulls it
  assign pin = ~(drive | ext_low);

  rst_pin_seq u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pll_lock_i (lock),
    .pin_i      (pin),
    .pin_drive_o(drive),
    .core_rst_o (core_rst),
    .por_flag_o (por_flag)
  );

  task automatic chk_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic lock_v, input logic ext_v);
    @(negedge clk);
    rst_n   = 1'b0;
    lock    = lock_v;
    ext_low = ext_v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // follows the sequence until the core leaves reset, checking window lengths;
  // frees the outside agent at release window free_loop, sample free_idx
  task automatic walk(input int free_loop, input int free_idx, input bit init_d,
                      input int init_low, output int n_low);
    int  loop = 0;
    int  low_len = init_low;
    int  rel_len = 0;
    int  guard = 0;
    bit  prev_d = init_d;
    n_low = 0;
    forever begin
      @(negedge clk);
      guard++;
      if (guard > 20000) begin
        chk_eq("R6 sequence never ended", guard, 0);
        break;
      end
      if (!core_rst) begin
        chk_eq(loop == 0 ? "R2 probe release length" : "R5 final release length",
               rel_len, loop == 0 ? PRB + SYN : REL);
        chk_eq("R7 pull-down off at exit", int'(drive), 0);
        break;
      end
      if (drive) begin
        if (!prev_d && rel_len > 0)
          chk_eq(loop == 0 ? "R2 probe release length" : "R5 release length",
                 rel_len, loop == 0 ? PRB + SYN : REL);
        low_len++;
      end else begin
        if (prev_d) begin
          if (low_len > 0) begin
            chk_eq("R4 drive-low length", low_len, LOW);
            n_low++;
            loop++;
          end
          low_len = 0;
          rel_len = 0;
        end
        rel_len++;
        if (ext_low && loop == free_loop && rel_len == free_idx) ext_low = 1'b0;
      end
      prev_d = drive;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d cycles max", cyc, WATCHDOG);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    int nl;

    // reset state and hold while unlocked
    repeat (3) @(negedge clk);
    chk_eq("R1 drive in reset", int'(drive), 1);
    chk_eq("R1 core_rst in reset", int'(core_rst), 1);
    chk_eq("R1 flag in reset", int'(por_flag), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk_eq("R1 drive while unlocked", int'(drive), 1);
    end
    chk_eq("R1 core_rst while unlocked", int'(core_rst), 1);

    // power-on: line floats high at once
    lock = 1'b1;
    walk(99, 0, 1'b0, 0, nl);
    chk_eq("R3 no drive-low windows", nl, 0);
    chk_eq("R3 flag power-on", int'(por_flag), 1);

    // running: one-cycle low re-enters the loop on the third edge
    @(negedge clk);
    ext_low = 1'b1;
    @(negedge clk);
    ext_low = 1'b0;
    chk_eq("R9 no drive after 1 edge", int'(drive), 0);
    @(negedge clk);
    chk_eq("R9 no drive after 2 edges", int'(drive), 0);
    @(negedge clk);
    chk_eq("R9 drive after 3 edges", int'(drive), 1);
    chk_eq("R9 core_rst after 3 edges", int'(core_rst), 1);
    chk_eq("R8 flag held during sequence", int'(por_flag), 1);
    walk(99, 0, 1'b1, 1, nl);
    chk_eq("R6 re-entry loops", nl, 1);
    chk_eq("R7 flag external after re-entry", int'(por_flag), 0);

    // lock loss while running
    @(negedge clk);
    lock = 1'b0;
    @(negedge clk);
    chk_eq("R10 drive after lock loss", int'(drive), 1);
    chk_eq("R10 core_rst after lock loss", int'(core_rst), 1);
    repeat (4) @(negedge clk);
    chk_eq("R1 drive held unlocked", int'(drive), 1);
    chk_eq("R8 flag held in hold", int'(por_flag), 0);
    lock = 1'b1;
    walk(99, 0, 1'b0, 0, nl);
    chk_eq("R3 relock power-on loops", nl, 0);
    chk_eq("R3 relock flag", int'(por_flag), 1);

    // probe boundary: rise in 2nd released cycle counts, 3rd does not
    do_reset(1'b1, 1'b1);
    walk(0, 2, 1'b0, 0, nl);
    chk_eq("R3 late-probe power-on loops", nl, 0);
    chk_eq("R3 late-probe flag", int'(por_flag), 1);

    do_reset(1'b1, 1'b1);
    walk(0, 3, 1'b0, 0, nl);
    chk_eq("R4 missed-probe loops", nl, 1);
    chk_eq("R7 missed-probe flag", int'(por_flag), 0);

    // loop count sweep: freed in 8th cycle of release window k
    for (int k = 1; k <= 3; k++) begin
      do_reset(1'b1, 1'b1);
      walk(k, 8, 1'b0, 0, nl);
      chk_eq("R6 loop count", nl, k);
      chk_eq("R7 flag external", int'(por_flag), 0);
    end

    // rise in 9th or 10th release cycle is too late
    for (int idx = 9; idx <= 10; idx++) begin
      do_reset(1'b1, 1'b1);
      walk(1, idx, 1'b0, 0, nl);
      chk_eq("R5 late rise costs a loop", nl, 2);
    end

    // lock loss during drive-low
    do_reset(1'b1, 1'b1);
    repeat (100) @(negedge clk);
    chk_eq("R4 driving mid-window", int'(drive), 1);
    lock = 1'b0;
    @(negedge clk);
    ext_low = 1'b0;
    chk_eq("R10 drive after lock loss in window", int'(drive), 1);
    chk_eq("R10 core_rst after lock loss in window", int'(core_rst), 1);
    repeat (3) @(negedge clk);
    lock = 1'b1;
    walk(99, 0, 1'b0, 0, nl);
    chk_eq("R10 restart from probe", nl, 0);
    chk_eq("R3 flag after restart", int'(por_flag), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule